// File: doc/BRIEF.md
# Subtract-and-Branch-if-Nonpositive Processor Core

This core executes programs built from a single implicit instruction and has no opcode field. Each instruction takes three consecutive words of a shared, word-addressed memory: a source address, a destination address and a branch target. The core subtracts the source word from the destination word and stores the difference back at the destination. It then jumps to the target if the stored result is zero or negative, and otherwise steps to the next instruction. Code and data share the same memory, so programs may rewrite their own instructions.

A negative source or destination address, or a taken jump to a negative target, stops the machine. The `halted` output then holds high until reset. While reset is held, a simple load port writes memory words, and a debug port reads any word at any time. This lets the surrounding environment place a program, release reset and inspect the results. Words are 16-bit two's complement in a 256-word memory. The core uses one synchronous memory port and spends seven clock cycles on each instruction.

Top module: `sbleq_core`

## Requirements
- R1: While `rst` is high, `halted` is low and the program counter is 0. The first instruction after `rst` falls is taken from words 0, 1 and 2.
- R2: `ld_we` writes `ld_data` to word `ld_addr` only while `rst` is high. With `rst` low it changes no memory word. `dbg_data` always shows the word at `dbg_addr` without a clock delay.
- R3: An instruction at program counter p reads a = word p, b = word p+1 and c = word p+2. It stores word[b] − word[a] at word b, wrapping modulo 2^16 (for example −32768 − 1 stores 32767).
- R4: If the stored result, read as signed, is ≤ 0, the program counter becomes c. Otherwise it becomes p+3 modulo 256, so an instruction at 254 falls through to 1.
- R5: A completed instruction takes exactly 7 clock cycles. The next instruction's first fetch follows directly.
- R6: If a or b is negative (bit 15 set), the core halts: `halted` rises after the 4th rising edge of that instruction and no memory word is written.
- R7: A taken branch to a negative c sets `halted` after the 7th rising edge of that instruction. A negative c has no effect when the branch is not taken.
- R8: A non-negative address or target uses only its low 8 bits (for example 0x0114 addresses word 20).
- R9: Once high, `halted` stays high and no memory word changes until `rst` is asserted.
- R10: All three instruction words are fetched before the write-back. An instruction that overwrites its own words still uses the old values, and the new values take effect on the next fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| ld_we | input | 1 | Load write enable (only honoured in reset) |
| ld_addr | input | 8 | Load word address |
| ld_data | input | 16 | Load word value |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 16 | Word at `dbg_addr`, combinational |
| halted | output | 1 | Machine has stopped |

## Verification
The bench targets these corner cases:
- An instruction that overwrites its own target word. A core that fetched the target after write-back would jump to the new value.
- A later instruction patched so that its source becomes negative. A core that cached instructions would never stop.
- Subtraction that overflows 16 bits, and a negative target on a branch that is not taken. Mishandling either one misjudges the sign and causes a false halt or a wrong jump.
- Addresses with high bits set, and program-counter wrap at word 255. Getting these wrong sends execution to the wrong word.
- Load writes attempted while the core runs. Honouring them corrupts the countdown data.
The halt cycle is compared on every clock, so a halt that comes one cycle early or late is reported, as is any memory write after halting.

// File: rtl/sbleq_core.sv
module sbleq_core #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] S_FA = 3'd0, S_FB = 3'd1, S_FC = 3'd2, S_FD = 3'd3,
                         S_RA = 3'd4, S_RB = 3'd5, S_PC = 3'd6, S_HLT = 3'd7;

  logic [DW-1:0] mem [DEPTH];
  logic [2:0]    st;
  logic [AW-1:0] pc, core_addr;
  logic [DW-1:0] a_q, b_q, c_q, va_q, rd_q, res_q, diff;
  logic          core_en, core_we, ops_neg, res_le;

  assign diff    = rd_q - va_q;
  assign ops_neg = a_q[DW-1] | b_q[DW-1];
  assign res_le  = res_q[DW-1] | (res_q == '0);
  assign halted  = (st == S_HLT);
  assign dbg_data = mem[dbg_addr];

  always_comb begin
    core_en   = 1'b0;
    core_we   = 1'b0;
    core_addr = pc;
    case (st)
      S_FA: core_en = 1'b1;
      S_FB: begin core_en = 1'b1; core_addr = pc + AW'(1); end
      S_FC: begin core_en = 1'b1; core_addr = pc + AW'(2); end
      S_FD: begin core_en = !ops_neg; core_addr = a_q[AW-1:0]; end
      S_RA: begin core_en = 1'b1; core_addr = b_q[AW-1:0]; end
      S_RB: begin core_en = 1'b1; core_we = 1'b1; core_addr = b_q[AW-1:0]; end
      default: ;
    endcase
    if (rst) core_en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we) mem[ld_addr] <= ld_data;
    end else if (core_en) begin
      if (core_we) mem[core_addr] <= diff;
      rd_q <= mem[core_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FA;
      pc <= '0;
    end else begin
      case (st)
        S_FA: st <= S_FB;
        S_FB: begin a_q <= rd_q; st <= S_FC; end
        S_FC: begin b_q <= rd_q; st <= S_FD; end
        S_FD: begin c_q <= rd_q; st <= ops_neg ? S_HLT : S_RA; end
        S_RA: begin va_q <= rd_q; st <= S_RB; end
        S_RB: begin res_q <= diff; st <= S_PC; end
        S_PC: begin
          if (res_le && c_q[DW-1]) begin
            st <= S_HLT;
          end else begin
            pc <= res_le ? c_q[AW-1:0] : pc + AW'(3);
            st <= S_FA;
          end
        end
        default: st <= S_HLT;
      endcase
    end
  end
endmodule

// File: rtl/sbleq_core_chk.sv
module sbleq_core_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic [2:0]    st,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q,
  input logic [DW-1:0] c_q,
  input logic [DW-1:0] res_q,
  input logic          core_en
);
  logic le;
  assign le = res_q[DW-1] || (res_q == '0);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!halted && pc == '0));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) halted |-> !core_en);
  // R4
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd6 && !le) |=> pc == AW'($past(pc) + AW'(3)));
  // R4
  branch_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd6 && le && !c_q[DW-1]) |=> pc == $past(c_q[AW-1:0]));
  // R6
  operand_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3 && (a_q[DW-1] || b_q[DW-1])) |=> halted);
  // R7
  neg_target_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd6 && le && c_q[DW-1]) |=> halted);
endmodule

bind sbleq_core sbleq_core_chk #(.DW(DW), .AW(AW)) chk (.*);

// File: tb/sbleq_core_test.sv
module sbleq_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  logic halted;

  int checks = 0, errors = 0, cycles = 0;

  logic signed [15:0] img [256];
  logic signed [15:0] m [256];
  logic signed [15:0] fa, fb, fc, res;
  int  m_pc = 0, m_cyc = 0;
  bit  exp_halt = 1'b0, model_on = 1'b0, m_init = 1'b0;

  sbleq_core uut (.clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
                  .ld_data(ld_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
                  .halted(halted));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R5: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (m_init) begin
      for (int i = 0; i < 256; i++) m[i] = img[i];
      m_pc = 0; m_cyc = 0; exp_halt = 1'b0;
    end else if (model_on && !rst && !exp_halt) begin
      m_cyc++;
      if (m_cyc == 1) begin
        fa = m[m_pc]; fb = m[(m_pc + 1) % 256]; fc = m[(m_pc + 2) % 256];
      end
      if (m_cyc == 4 && (fa < 0 || fb < 0)) exp_halt = 1'b1;
      else if (m_cyc == 7) begin
        res = m[fb[7:0]] - m[fa[7:0]];
        m[fb[7:0]] = res;
        if (res <= 0) begin
          if (fc < 0) exp_halt = 1'b1;
          else m_pc = int'(fc[7:0]);
        end else m_pc = (m_pc + 3) % 256;
        m_cyc = 0;
      end
    end
  end

  // per-cycle compare of the halt flag
  always @(negedge clk) begin
    if (model_on && !rst) begin
      checks++;
      if (halted !== exp_halt) begin
        errors++;
        $display("FAIL R5 R6 R7 halted timing: actual %0b expected %0b", halted, exp_halt);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic put(input int adr, input int val);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 8'(adr); ld_data = 16'(val);
    img[adr] = 16'(val);
  endtask

  task automatic clear_mem;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) put(i, 0);
  endtask

  task automatic run(input string tag, input bit garble);
    int n;
    @(negedge clk);
    ld_we = 1'b0; m_init = 1'b1;
    @(negedge clk);
    m_init = 1'b0; model_on = 1'b1; rst = 1'b0;
    if (garble) begin ld_we = 1'b1; ld_addr = 8'd31; ld_data = 16'd999; end
    n = 0;
    while (!(exp_halt && halted) && n < 3000) begin @(negedge clk); n++; end
    repeat (12) @(negedge clk);
    ld_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      dbg_addr = 8'(i); #1;
      chk(tag, dbg_data, m[i]);
    end
    model_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset halted low", {15'd0, halted}, 16'd0);

    // Program A: R3 R4 R8 basic subtract, fall-through, branch, truncated address
    clear_mem;
    put(0, 16'h0114); put(1, 21); put(2, 3);
    put(3, 22); put(4, 22); put(5, 9);
    put(6, 20); put(7, 21); put(8, -1);
    put(9, 23); put(10, 21); put(11, 16'h010C);
    put(12, -1); put(13, 0); put(14, 0);
    put(20, 3); put(21, 5); put(22, 9); put(23, 7);
    run("R3 R4 R8 program A memory", 1'b0);
    chk("R9 halted held A", {15'd0, halted}, 16'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 halted cleared by reset", {15'd0, halted}, 16'd0);

    // Program B: R2 R4 R7 countdown loop, load port driven while running
    clear_mem;
    put(0, 30); put(1, 31); put(2, 6);
    put(3, 32); put(4, 32); put(5, 0);
    put(6, 32); put(7, 32); put(8, -1);
    put(30, 1); put(31, 5); put(32, 7);
    run("R2 R7 program B memory", 1'b1);
    dbg_addr = 8'd31; #1;
    chk("R2 ignored load during run", dbg_data, 16'd0);

    // Program C: R3 overflow wrap, R7 untaken negative target, R6 negative b
    clear_mem;
    put(0, 40); put(1, 41); put(2, -7);
    put(3, 0); put(4, -5); put(5, 0);
    put(40, 1); put(41, -32768);
    run("R3 R6 R7 program C memory", 1'b0);
    dbg_addr = 8'd41; #1;
    chk("R3 wrap result", dbg_data, 16'd32767);

    // Program D: R10 self-modifying target word and later operand
    clear_mem;
    put(0, 20); put(1, 2); put(2, 9);
    put(9, 21); put(10, 12); put(11, 12);
    put(12, 4); put(13, 0); put(14, 0);
    put(20, 9); put(21, 10);
    run("R10 program D memory", 1'b0);
    dbg_addr = 8'd12; #1;
    chk("R10 patched operand", dbg_data, 16'hFFFA);

    // Program E: R4 program counter wrap past word 255
    clear_mem;
    put(0, 63); put(1, 63); put(2, 254);
    put(3, 0); put(4, -1); put(5, 0); put(6, 0);
    put(61, 1); put(62, 5);
    put(254, 61); put(255, 62);
    run("R4 program E memory", 1'b0);
    chk("R9 halted held E", {15'd0, halted}, 16'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule